// File: doc/BRIEF.md
# ATM Filler Cell Generator

This block produces a complete filler cell for an ATM transmit path: five header octets followed by a payload. It sends the cell as a stream of bytes whenever the transmit side has no user cell to send. The transmit scheduler holds `fill_req_i` high while it wants filler traffic. The generator answers with a valid/ready byte stream that carries start-of-cell and end-of-cell markers.

The header comes from one 8-bit header setting. Its upper nibble fills the generic-flow / high path-identifier field of the first octet. Its low nibble supplies the payload-type and cell-loss-priority bits at the bottom of the fourth octet. Every other address bit is zero. The payload is a single 8-bit setting, repeated once for every payload octet.

The fifth octet is sent as zero and marked with a strobe, so that a later header-check stage can overwrite it. Both settings are captured when a cell starts. A header setting of 0x01 with payload 0x6A gives the standard idle cell. A header setting of the form 0000xxx0 gives an unassigned cell.

Top module: `atm_fill_gen`

## Requirements
- R1: After a synchronous reset, `out_valid_o`, `out_sop_o`, `out_eop_o` and `out_hec_o` are all low.
- R2: While `fill_req_i` is low and no cell is in progress, `out_valid_o` stays low. When `fill_req_i` is sampled high by an idle block, the first octet is presented with `out_sop_o` high in the following cycle.
- R3: A cell is 5 + PL_OCTETS octets (53 by default). `out_sop_o` is high only on octet 1 and `out_eop_o` only on the last octet.
- R4: Octet 1 equals {hdr[7:4], 4'b0000}. Octets 2 and 3 are 0x00. Octet 4 equals {4'b0000, hdr[3:1], hdr[0]}, which places the payload-type field in bits 3:1 and the loss-priority bit in bit 0.
- R5: Octet 5 is 0x00, and `out_hec_o` is high on that octet and on no other.
- R6: Every payload octet, from octet 6 to the last, equals the payload setting.
- R7: A header setting of 0x01 with payload 0x6A yields the header octets 00 00 00 01 00, followed by 0x6A payload octets.
- R8: A header setting of 0x0E (form 0000xxx0) yields octet 4 = 0x0E, with octets 1 to 3 all zero.
- R9: Both settings are sampled in the cycle a cell is launched. A change while a cell is in progress has no effect on that cell and applies to the next one.
- R10: When `out_valid_o` is high and `out_ready_i` is low, the data and all markers hold their values in the next cycle. No octet is dropped or repeated under stalls.
- R11: If `fill_req_i` is high when the last octet is accepted, the next cell's first octet is presented in the very next cycle, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_req_i | input | 1 | Transmit path requests filler cells |
| cfg_hdr_i | input | 8 | Header setting: [7:4] upper field of octet 1, [3:1] payload type, [0] loss priority |
| cfg_pl_i | input | 8 | Payload octet value |
| out_ready_i | input | 1 | Downstream accepts the current octet |
| out_valid_o | output | 1 | Octet on `out_data_o` is valid |
| out_data_o | output | 8 | Cell octet |
| out_sop_o | output | 1 | First octet of a cell |
| out_eop_o | output | 1 | Last octet of a cell |
| out_hec_o | output | 1 | Octet is the header-check placeholder |

## Verification
The bench builds the block with the default PL_OCTETS of 48, so it sees the full 53-octet cell. With that setting the end-of-cell marker, the 48 repeated payload octets and the fifth-octet strobe all fall at their standard positions. The cell is short enough that both the idle and the unassigned header settings, a stalled cell, a mid-cell setting change and two back-to-back cells all fit in a few hundred cycles. The regular stall patterns cover holding on every kind of octet, including the first, the placeholder and the last.

// File: rtl/atm_fill_pkg.sv
package atm_fill_pkg;

  localparam int unsigned OCTET_W = 8;

  typedef logic [OCTET_W-1:0] octet_t;

  // snapshot of the two settings taken when a cell is launched
  typedef struct packed {
    octet_t hdr;
    octet_t pl;
  } fill_cfg_t;

  // what a given octet position carries
  typedef enum logic [1:0] {
    KIND_HDR_HI  = 2'd0,
    KIND_ZERO    = 2'd1,
    KIND_HDR_LO  = 2'd2,
    KIND_PAYLOAD = 2'd3
  } octet_kind_e;

endpackage

// File: rtl/fill_seq.sv
module fill_seq #(
  parameter int unsigned CELL_OCTETS = 53,
  parameter int unsigned IDX_W       = $clog2(CELL_OCTETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             fire_i,
  output logic             nxt_active_o,
  output logic [IDX_W-1:0] nxt_idx_o,
  output logic             launch_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_OCTETS - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic             at_last;

  assign at_last = (idx_q == LAST_IDX);

  always_comb begin
    launch_o     = req_i && (!active_q || (fire_i && at_last));
    nxt_active_o = active_q;
    nxt_idx_o    = idx_q;
    if (launch_o) begin
      nxt_active_o = 1'b1;
      nxt_idx_o    = '0;
    end else if (fire_i) begin
      if (at_last) begin
        nxt_active_o = 1'b0;
      end else begin
        nxt_idx_o = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= nxt_active_o;
      idx_q    <= nxt_idx_o;
    end
  end

endmodule

// File: rtl/fill_cfg_hold.sv
module fill_cfg_hold
  import atm_fill_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      launch_i,
  input  fill_cfg_t cfg_i,
  output fill_cfg_t cfg_use_o
);

  fill_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (launch_i) begin
      cfg_q <= cfg_i;
    end
  end

  // the launching cycle already forms octet 1 from the fresh settings
  assign cfg_use_o = launch_i ? cfg_i : cfg_q;

endmodule

// File: rtl/fill_octet_fmt.sv
module fill_octet_fmt
  import atm_fill_pkg::*;
#(
  parameter int unsigned CELL_OCTETS = 53,
  parameter int unsigned HDR_OCTETS  = 5,
  parameter int unsigned IDX_W       = $clog2(CELL_OCTETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nxt_active_i,
  input  logic [IDX_W-1:0] nxt_idx_i,
  input  fill_cfg_t        cfg_i,
  output logic             valid_o,
  output octet_t           data_o,
  output logic             sop_o,
  output logic             eop_o,
  output logic             hec_o
);

  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(CELL_OCTETS - 1);
  localparam logic [IDX_W-1:0] HEC_IDX   = IDX_W'(HDR_OCTETS - 1);
  localparam logic [IDX_W-1:0] LOADR_IDX = IDX_W'(HDR_OCTETS - 2);

  octet_kind_e kind;
  octet_t      octet_nxt;

  always_comb begin
    if (nxt_idx_i == '0)             kind = KIND_HDR_HI;
    else if (nxt_idx_i == LOADR_IDX) kind = KIND_HDR_LO;
    else if (nxt_idx_i <= HEC_IDX)   kind = KIND_ZERO;
    else                             kind = KIND_PAYLOAD;
  end

  always_comb begin
    unique case (kind)
      KIND_HDR_HI:  octet_nxt = {cfg_i.hdr[7:4], 4'h0};
      KIND_HDR_LO:  octet_nxt = {4'h0, cfg_i.hdr[3:0]};
      KIND_PAYLOAD: octet_nxt = cfg_i.pl;
      default:      octet_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      sop_o   <= 1'b0;
      eop_o   <= 1'b0;
      hec_o   <= 1'b0;
    end else begin
      valid_o <= nxt_active_i;
      data_o  <= nxt_active_i ? octet_nxt : '0;
      sop_o   <= nxt_active_i && (nxt_idx_i == '0);
      eop_o   <= nxt_active_i && (nxt_idx_i == LAST_IDX);
      hec_o   <= nxt_active_i && (nxt_idx_i == HEC_IDX);
    end
  end

endmodule

// File: rtl/atm_fill_gen.sv
module atm_fill_gen
  import atm_fill_pkg::*;
#(
  parameter int unsigned PL_OCTETS = 48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fill_req_i,
  input  logic [7:0] cfg_hdr_i,
  input  logic [7:0] cfg_pl_i,
  input  logic       out_ready_i,
  output logic       out_valid_o,
  output logic [7:0] out_data_o,
  output logic       out_sop_o,
  output logic       out_eop_o,
  output logic       out_hec_o
);

  localparam int unsigned HDR_OCTETS  = 5;
  localparam int unsigned CELL_OCTETS = HDR_OCTETS + PL_OCTETS;
  localparam int unsigned IDX_W       = $clog2(CELL_OCTETS);

  logic             fire;
  logic             launch;
  logic             nxt_active;
  logic [IDX_W-1:0] nxt_idx;
  fill_cfg_t        cfg_in;
  fill_cfg_t        cfg_use;

  assign fire   = out_valid_o && out_ready_i;
  assign cfg_in = '{hdr: cfg_hdr_i, pl: cfg_pl_i};

  fill_seq #(
    .CELL_OCTETS(CELL_OCTETS),
    .IDX_W      (IDX_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_i       (fill_req_i),
    .fire_i      (fire),
    .nxt_active_o(nxt_active),
    .nxt_idx_o   (nxt_idx),
    .launch_o    (launch)
  );

  fill_cfg_hold u_cfg (
    .clk      (clk),
    .rst      (rst),
    .launch_i (launch),
    .cfg_i    (cfg_in),
    .cfg_use_o(cfg_use)
  );

  fill_octet_fmt #(
    .CELL_OCTETS(CELL_OCTETS),
    .HDR_OCTETS (HDR_OCTETS),
    .IDX_W      (IDX_W)
  ) u_fmt (
    .clk         (clk),
    .rst         (rst),
    .nxt_active_i(nxt_active),
    .nxt_idx_i   (nxt_idx),
    .cfg_i       (cfg_use),
    .valid_o     (out_valid_o),
    .data_o      (out_data_o),
    .sop_o       (out_sop_o),
    .eop_o       (out_eop_o),
    .hec_o       (out_hec_o)
  );

endmodule

// File: rtl/atm_fill_chk.sv
module atm_fill_chk #(
  parameter int unsigned PL_OCTETS = 48
) (
  input logic       clk,
  input logic       rst,
  input logic       fill_req_i,
  input logic       out_ready_i,
  input logic       out_valid_o,
  input logic [7:0] out_data_o,
  input logic       out_sop_o,
  input logic       out_eop_o,
  input logic       out_hec_o
);

  localparam int unsigned CELL = PL_OCTETS + 5;
  localparam int unsigned PW   = $clog2(CELL) + 1;

  logic [PW-1:0] pos;
  logic          fire;

  assign fire = out_valid_o && out_ready_i;

  // independent count of accepted octets within the current cell
  always_ff @(posedge clk) begin
    if (rst)       pos <= '0;
    else if (fire) pos <= out_eop_o ? '0 : pos + 1'b1;
  end

  a_r2_quiet_without_req: assert property (@(posedge clk) disable iff (rst)
    (!out_valid_o && !fill_req_i) |=> !out_valid_o);

  a_r3_sop_at_first: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && out_sop_o) |-> (pos == '0));

  a_r3_eop_at_last: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && out_eop_o) |-> (pos == PW'(CELL - 1)));

  a_r4_zero_address_octets: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && (pos == PW'(1) || pos == PW'(2))) |-> (out_data_o == 8'h00));

  a_r5_hec_slot_zero: assert property (@(posedge clk) disable iff (rst)
    out_hec_o |-> (out_valid_o && out_data_o == 8'h00 && pos == PW'(4)));

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) &&
      $stable(out_sop_o) && $stable(out_eop_o) && $stable(out_hec_o)));

  a_r11_no_gap: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && out_ready_i && out_eop_o && fill_req_i) |=> (out_valid_o && out_sop_o));

endmodule

bind atm_fill_gen atm_fill_chk #(.PL_OCTETS(PL_OCTETS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fill_req_i (fill_req_i),
  .out_ready_i(out_ready_i),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .out_sop_o  (out_sop_o),
  .out_eop_o  (out_eop_o),
  .out_hec_o  (out_hec_o)
);

// File: tb/sim_atm_fill_gen.sv
`timescale 1ns/1ps
module sim_atm_fill_gen;

  localparam int CELL = 53;

  logic       clk = 1'b0;
  logic       rst;
  logic       fill_req_i;
  logic [7:0] cfg_hdr_i;
  logic [7:0] cfg_pl_i;
  logic       out_ready_i;
  logic       out_valid_o;
  logic [7:0] out_data_o;
  logic       out_sop_o;
  logic       out_eop_o;
  logic       out_hec_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] cap_d [CELL];
  logic [2:0] cap_f [CELL];

  always #10 clk = ~clk;

  atm_fill_gen #(.PL_OCTETS(48)) u0 (
    .clk(clk), .rst(rst), .fill_req_i(fill_req_i), .cfg_hdr_i(cfg_hdr_i),
    .cfg_pl_i(cfg_pl_i), .out_ready_i(out_ready_i), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .out_sop_o(out_sop_o), .out_eop_o(out_eop_o),
    .out_hec_o(out_hec_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Starts at a falling edge where a cell is about to be or is presented.
  // Returns at the falling edge where the last octet is being accepted.
  task automatic grab(input int stall_mod, input int chg_at,
                      input logic [7:0] nh, input logic [7:0] np);
    int n = 0;
    int guard = 0;
    bit was_stall = 1'b0;
    logic [7:0] pd = '0;
    logic [2:0] pf = '0;
    while (n < CELL && guard < 2000) begin
      logic rdy;
      if (was_stall)
        chk(out_valid_o && out_data_o == pd && {out_sop_o, out_eop_o, out_hec_o} == pf,
            "R10 hold", {out_valid_o, out_data_o}, {1'b1, pd});
      rdy = (stall_mod == 0) ? 1'b1 : ((guard % stall_mod) != 0);
      out_ready_i = rdy;
      was_stall = out_valid_o && !rdy;
      pd = out_data_o;
      pf = {out_sop_o, out_eop_o, out_hec_o};
      if (out_valid_o && rdy) begin
        cap_d[n] = out_data_o;
        cap_f[n] = {out_sop_o, out_eop_o, out_hec_o};
        n++;
        if (n == chg_at) begin
          cfg_hdr_i = nh;
          cfg_pl_i  = np;
        end
      end
      guard++;
      if (n < CELL) @(negedge clk);
    end
    chk(n == CELL, "R3 octet count", n, CELL);
  endtask

  task automatic check_cell(input logic [7:0] h, input logic [7:0] p, input string tag);
    for (int i = 0; i < CELL; i++) begin
      logic [7:0] e;
      string r;
      if (i == 0)      e = {h[7:4], 4'h0};
      else if (i == 3) e = {4'h0, h[3:0]};
      else if (i < 5)  e = 8'h00;
      else             e = p;
      r = (i < 4) ? "R4" : (i == 4) ? "R5" : "R6";
      chk(cap_d[i] == e, $sformatf("%s/%s octet %0d", tag, r, i + 1), cap_d[i], e);
      chk(cap_f[i] == {(i == 0), (i == CELL - 1), (i == 4)},
          $sformatf("%s/R3 flags octet %0d", tag, i + 1), cap_f[i],
          {(i == 0), (i == CELL - 1), (i == 4)});
    end
  endtask

  // launch one cell with req raised at a falling edge; req drops at the end
  task automatic single_cell(input logic [7:0] h, input logic [7:0] p,
                             input int stall_mod, input string tag);
    cfg_hdr_i  = h;
    cfg_pl_i   = p;
    fill_req_i = 1'b1;
    @(negedge clk);
    chk(out_valid_o && out_sop_o, {tag, "/R2 latency"}, {out_valid_o, out_sop_o}, 2'b11);
    grab(stall_mod, -1, 8'h00, 8'h00);
    fill_req_i = 1'b0;
    @(negedge clk);
    chk(!out_valid_o, {tag, "/R2 stop"}, out_valid_o, 0);
    check_cell(h, p, tag);
  endtask

  task automatic t_reset;
    rst = 1'b1; fill_req_i = 1'b0; out_ready_i = 1'b1;
    cfg_hdr_i = 8'h00; cfg_pl_i = 8'h00;
    repeat (3) @(negedge clk);
    chk({out_valid_o, out_sop_o, out_eop_o, out_hec_o} == 4'b0, "R1 reset",
        {out_valid_o, out_sop_o, out_eop_o, out_hec_o}, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_no_req;
    bit seen = 1'b0;
    cfg_hdr_i = 8'hFF; cfg_pl_i = 8'hFF;
    repeat (12) begin
      @(negedge clk);
      if (out_valid_o) seen = 1'b1;
    end
    chk(!seen, "R2 quiet without request", seen, 0);
  endtask

  task automatic t_idle;
    single_cell(8'h01, 8'h6A, 0, "R7 idle");
  endtask

  task automatic t_unassigned;
    single_cell(8'h0E, 8'h00, 0, "R8 unassigned");
  endtask

  task automatic t_stall;
    single_cell(8'hA7, 8'h3C, 3, "R10 stall3");
    single_cell(8'h5B, 8'hC3, 2, "R10 stall2");
  endtask

  task automatic t_midcell;
    cfg_hdr_i = 8'h51; cfg_pl_i = 8'h11; fill_req_i = 1'b1;
    @(negedge clk);
    grab(0, 10, 8'hF3, 8'hCC);
    fill_req_i = 1'b0;
    @(negedge clk);
    check_cell(8'h51, 8'h11, "R9 old");
    fill_req_i = 1'b1;
    @(negedge clk);
    grab(0, -1, 8'h00, 8'h00);
    fill_req_i = 1'b0;
    @(negedge clk);
    check_cell(8'hF3, 8'hCC, "R9 next");
  endtask

  task automatic t_b2b;
    cfg_hdr_i = 8'h32; cfg_pl_i = 8'h5A; fill_req_i = 1'b1;
    @(negedge clk);
    grab(0, -1, 8'h00, 8'h00);
    cfg_hdr_i = 8'hC9; cfg_pl_i = 8'h96;
    @(negedge clk);
    chk(out_valid_o && out_sop_o, "R11 no gap", {out_valid_o, out_sop_o}, 2'b11);
    check_cell(8'h32, 8'h5A, "R11 first");
    grab(0, -1, 8'h00, 8'h00);
    fill_req_i = 1'b0;
    @(negedge clk);
    chk(!out_valid_o, "R11 stop", out_valid_o, 0);
    check_cell(8'hC9, 8'h96, "R11 second");
  endtask

  initial begin
    t_reset();
    t_no_req();
    t_idle();
    t_unassigned();
    t_stall();
    t_midcell();
    t_b2b();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule